// File: doc/BRIEF.md
# Two-Input Configurable Logic/Storage Cell

This block is a small reconfigurable logic element with two signal inputs and one signal output. A static configuration word sets what the cell does. The word has one mode bit and a 4-bit function field. With the mode bit clear, the cell is a two-input lookup table: the two inputs pick one bit of the function field, and that bit reaches the output through combinational logic only. With the mode bit set, the cell is a one-bit storage element. Input 0 is its clock and input 1 is its data. The storage element can be an edge-triggered flip-flop or a transparent-low latch. Its output can be true or inverted, and its initial value is programmable.

The whole cell runs on a system clock, and the cell's own clock input is handled as ordinary data. The design detects a rising edge on input 0 by comparing it with a registered copy. In latch mode the design samples input 0 each system cycle. The configuration word is registered, so a new word takes effect one system cycle after it is applied. A synchronous reset loads the stored bit from the initial-value bit of the incoming word. A reload strobe, pulsed when the word changes, does the same.

Top module: `lutff_cell`

## Requirements
- R1: With mode = 0, the output equals bit {in1,in0} of the function field. Bit 0 holds the result for in1=0 and in0=0, and bit 3 holds the result for in1=1 and in0=1. There is no clock edge between an input change and the output change.
- R2: A new configuration word, applied at the ports, changes the output only after the next rising edge of the system clock.
- R3: While rst = 1 or reload = 1 at a system clock edge, the stored bit takes the value of function-field bit 1 (the initial value) of the configuration word at the ports. Reset and reload take priority over any capture.
- R4: With mode = 1 and function-field bit 3 = 0 (flip-flop), the stored bit takes in1 at the first system clock edge that finds in0 high after finding it low.
- R5: In flip-flop mode, the stored bit keeps its value while in0 stays high, while in0 stays low, and when in0 falls, whatever in1 does.
- R6: With mode = 1 and function-field bit 3 = 1 (latch), the stored bit follows in1 at every system clock edge that finds in0 low. It holds at every edge that finds in0 high.
- R7: With mode = 1, the output is the stored bit when function-field bit 2 = 0 and its inverse when bit 2 = 1.
- R8: With mode = 1, function-field bit 0 has no effect on the output.
- R9: With mode = 0, the stored bit holds its value, so a later return to mode = 1 without a reload shows the bit as it was before.
- R10: The flip-flop's edge detector is re-armed on reset and reload with the current in0. A level of in0 that is already high across a reset or reload does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the configuration and the initial stored value |
| reload | input | 1 | Strobe pulsed when the configuration word changes; reloads the stored bit from the initial-value bit |
| cfg_mode | input | 1 | 0: lookup table, 1: storage element |
| cfg_field | input | 4 | Truth table in mode 0; in mode 1, bit 3 latch select, bit 2 invert output, bit 1 initial value, bit 0 unused |
| in0 | input | 1 | Table address bit 0, or storage clock |
| in1 | input | 1 | Table address bit 1, or storage data |
| cell_out | output | 1 | Cell output |

## Verification
The assertions assume the configuration word stays stable except when the controller deliberately rewrites it. They assume any rewrite that should restart the storage element comes with a reload pulse. They also assume in0 and in1 are synchronous to the system clock and hold for at least one cycle, because an edge or a latch level is seen only once sampled. The stimulus changes every input just after a system clock edge and holds it for whole cycles. It pulses reload together with each storage-mode configuration change, except in the single test that deliberately switches mode without one to show that the stored bit is retained.

// File: rtl/lutff_pkg.sv
package lutff_pkg;

    localparam int IN_W  = 2;
    localparam int FLD_W = 1 << IN_W;

    localparam int LATCH_BIT = FLD_W - 1;
    localparam int INV_BIT   = FLD_W - 2;
    localparam int INIT_BIT  = FLD_W - 3;

    typedef enum logic {
        MODE_TABLE = 1'b0,
        MODE_STORE = 1'b1
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e        mode;
        logic [FLD_W-1:0]  fld;
    } cell_cfg_t;

    typedef struct packed {
        logic latch_sel;
        logic out_inv;
        logic init_val;
    } store_ctl_t;

    function automatic store_ctl_t unpack_store(input logic [FLD_W-1:0] f);
        store_ctl_t s;
        s.latch_sel = f[LATCH_BIT];
        s.out_inv   = f[INV_BIT];
        s.init_val  = f[INIT_BIT];
        return s;
    endfunction

endpackage

// File: rtl/lutff_cfg_reg.sv
module lutff_cfg_reg
    import lutff_pkg::*;
(
    input  logic      clk,
    input  cell_cfg_t cfg_in,
    output cell_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        cfg_q <= cfg_in;
    end

endmodule

// File: rtl/lutff_table.sv
module lutff_table
    import lutff_pkg::*;
(
    input  logic [FLD_W-1:0] fld,
    input  logic [IN_W-1:0]  addr,
    output logic             y
);

    logic [FLD_W-1:0] hit;

    for (genvar i = 0; i < FLD_W; i++) begin : g_row
        assign hit[i] = fld[i] && (addr == IN_W'(i));
    end

    assign y = |hit;

endmodule

// File: rtl/lutff_store.sv
module lutff_store
    import lutff_pkg::*;
(
    input  logic       clk,
    input  logic       load,
    input  logic       load_val,
    input  logic       enable,
    input  logic       latch_sel,
    input  logic       sclk,
    input  logic       sdata,
    output logic       q,
    output logic       sclk_prev
);

    logic rise;
    logic capture;

    assign rise    = sclk && !sclk_prev;
    assign capture = enable && (latch_sel ? !sclk : rise);

    always_ff @(posedge clk) begin
        sclk_prev <= sclk;
        if (load) begin
            q <= load_val;
        end else if (capture) begin
            q <= sdata;
        end
    end

endmodule

// File: rtl/lutff_cell.sv
module lutff_cell
    import lutff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             cfg_mode,
    input  logic [FLD_W-1:0] cfg_field,
    input  logic             in0,
    input  logic             in1,
    output logic             cell_out
);

    cell_cfg_t  cfg_in;
    cell_cfg_t  cfg_q;
    store_ctl_t ctl_q;
    store_ctl_t ctl_in;
    logic       table_y;
    logic       q_state;
    logic       sclk_prev;
    logic       load;

    assign cfg_in.mode = cell_mode_e'(cfg_mode);
    assign cfg_in.fld  = cfg_field;

    assign ctl_in = unpack_store(cfg_field);
    assign ctl_q  = unpack_store(cfg_q.fld);
    assign load   = rst || reload;

    lutff_cfg_reg u_cfg (
        .clk    (clk),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    lutff_table u_tbl (
        .fld  (cfg_q.fld),
        .addr ({in1, in0}),
        .y    (table_y)
    );

    lutff_store u_st (
        .clk       (clk),
        .load      (load),
        .load_val  (ctl_in.init_val),
        .enable    (cfg_q.mode == MODE_STORE),
        .latch_sel (ctl_q.latch_sel),
        .sclk      (in0),
        .sdata     (in1),
        .q         (q_state),
        .sclk_prev (sclk_prev)
    );

    always_comb begin
        if (cfg_q.mode == MODE_STORE) begin
            cell_out = q_state ^ ctl_q.out_inv;
        end else begin
            cell_out = table_y;
        end
    end

endmodule

// File: rtl/lutff_cell_chk.sv
module lutff_cell_chk
    import lutff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [FLD_W-1:0] cfg_field,
    input  logic             in0,
    input  logic             in1,
    input  logic             cell_out,
    input  cell_cfg_t        cfg_q,
    input  logic             q_state,
    input  logic             sclk_prev
);

    logic is_store;
    assign is_store = (cfg_q.mode == MODE_STORE);

    // R1: table output for address 3 comes from the top field bit
    a_r1_table_top: assert property (@(posedge clk) disable iff (rst)
        (!is_store && in0 && in1) |-> (cell_out == cfg_q.fld[3]));

    // R3: reload loads the initial-value bit
    a_r3_reload_init: assert property (@(posedge clk) disable iff (rst)
        reload |=> (q_state == $past(cfg_field[INIT_BIT])));

    // R4: flip-flop captures data on a detected rising edge
    a_r4_ff_capture: assert property (@(posedge clk) disable iff (rst)
        (!reload && is_store && !cfg_q.fld[LATCH_BIT] && in0 && !sclk_prev)
        |=> (q_state == $past(in1)));

    // R5: flip-flop holds when no rising edge
    a_r5_ff_hold: assert property (@(posedge clk) disable iff (rst)
        (!reload && is_store && !cfg_q.fld[LATCH_BIT] && !(in0 && !sclk_prev))
        |=> $stable(q_state));

    // R6: latch transparent while clock low, holds while high
    a_r6_latch_follow: assert property (@(posedge clk) disable iff (rst)
        (!reload && is_store && cfg_q.fld[LATCH_BIT] && !in0)
        |=> (q_state == $past(in1)));

    a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (!reload && is_store && cfg_q.fld[LATCH_BIT] && in0)
        |=> $stable(q_state));

    // R7: storage output polarity
    a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
        is_store |-> (cell_out != (q_state == cfg_q.fld[INV_BIT])));

    // R9: stored bit frozen in table mode
    a_r9_table_hold: assert property (@(posedge clk) disable iff (rst)
        (!reload && !is_store) |=> $stable(q_state));

    // R10: edge detector tracks in0
    a_r10_prev_track: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sclk_prev == $past(in0)));

endmodule

bind lutff_cell lutff_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reload    (reload),
    .cfg_field (cfg_field),
    .in0       (in0),
    .in1       (in1),
    .cell_out  (cell_out),
    .cfg_q     (cfg_q),
    .q_state   (q_state),
    .sclk_prev (sclk_prev)
);

// File: tb/tb_lutff_cell.sv
module tb_lutff_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reload = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [3:0] cfg_field = 4'b0000;
    logic       in0 = 1'b0;
    logic       in1 = 1'b0;
    logic       cell_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lutff_cell dut (
        .clk       (clk),
        .rst       (rst),
        .reload    (reload),
        .cfg_mode  (cfg_mode),
        .cfg_field (cfg_field),
        .in0       (in0),
        .in1       (in1),
        .cell_out  (cell_out)
    );

    // {field[3:0], in1, in0, expected, unused}
    localparam logic [7:0] VEC [10] = '{
        {4'b1000, 1'b1, 1'b1, 1'b1, 1'b0},   // AND
        {4'b1000, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'b1110, 1'b0, 1'b0, 1'b0, 1'b0},   // OR
        {4'b1110, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'b0110, 1'b1, 1'b1, 1'b0, 1'b0},   // XOR
        {4'b0110, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'b1001, 1'b0, 1'b0, 1'b1, 1'b0},   // XNOR
        {4'b0111, 1'b1, 1'b1, 1'b0, 1'b0},   // NAND
        {4'b0001, 1'b0, 1'b0, 1'b1, 1'b0},   // NOR
        {4'b0100, 1'b1, 1'b0, 1'b1, 1'b0}    // in1 only, not in0
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic exp);
        n_cmp++;
        if (cell_out !== exp) begin
            n_bad++;
            $display("FAIL %s: cell_out=%b expected=%b at %0t", req, cell_out, exp, $time);
        end
    endtask

    task automatic set_cfg(input logic m, input logic [3:0] f, input logic rl);
        cfg_mode  = m;
        cfg_field = f;
        reload    = rl;
        tick();
        reload    = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: expired expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R3 reset loads initial value 1
        rst = 1'b1; cfg_mode = 1'b1; cfg_field = 4'b0010;
        tick();
        check("R3 reset init=1", 1'b1);
        // R3 + R7 reset with init=1, inverted output
        cfg_field = 4'b0110;
        tick();
        check("R3 reset init=1 inverted", 1'b0);
        rst = 1'b0;

        // R1 table vectors
        for (int i = 0; i < 10; i++) begin
            set_cfg(1'b0, VEC[i][7:4], 1'b0);
            in1 = VEC[i][3];
            in0 = VEC[i][2];
            #1;
            check("R1 table lookup", VEC[i][1]);
        end

        // R1 purely combinational: input change visible before any edge
        set_cfg(1'b0, 4'b0110, 1'b0);
        in1 = 1'b0; in0 = 1'b0; #1;
        check("R1 comb xor 00", 1'b0);
        in0 = 1'b1; #1;
        check("R1 comb xor 01", 1'b1);

        // R2 config takes effect after next edge
        set_cfg(1'b0, 4'b1000, 1'b0);
        in1 = 1'b1; in0 = 1'b1; #1;
        check("R2 before change", 1'b1);
        cfg_field = 4'b0000; #1;
        check("R2 old config still visible", 1'b1);
        tick();
        check("R2 new config after edge", 1'b0);

        // Flip-flop: init 1, non-inverted
        in0 = 1'b0; in1 = 1'b0;
        set_cfg(1'b1, 4'b0010, 1'b1);
        check("R3 reload init=1", 1'b1);
        in0 = 1'b1; tick(); tick();
        check("R4 ff captures 0 on rise", 1'b0);
        in1 = 1'b1; tick(); tick();
        check("R5 ff hold while clk high", 1'b0);
        in0 = 1'b0; tick(); tick();
        check("R5 ff hold on fall/low", 1'b0);
        in0 = 1'b1; tick();
        check("R4 ff captures 1 on rise", 1'b1);

        // R10: in0 high across reload is not an edge
        in0 = 1'b1; in1 = 1'b1;
        set_cfg(1'b1, 4'b0000, 1'b1);
        check("R3 reload init=0", 1'b0);
        tick(); tick();
        check("R10 no edge across reload", 1'b0);

        // Latch mode, init 0
        in0 = 1'b1; in1 = 1'b1;
        set_cfg(1'b1, 4'b1000, 1'b1);
        check("R3 latch reload init=0", 1'b0);
        tick();
        check("R6 latch holds while clk high", 1'b0);
        in0 = 1'b0; tick(); tick();
        check("R6 latch follows 1 while clk low", 1'b1);
        in1 = 1'b0; tick(); tick();
        check("R6 latch follows 0 while clk low", 1'b0);
        in0 = 1'b1; tick(); in1 = 1'b1; tick(); tick();
        check("R6 latch holds after clk rises", 1'b0);

        // R7 inverted output, R8 field bit 0 ignored
        for (int b = 0; b < 2; b++) begin
            in0 = 1'b0; in1 = 1'b1;
            set_cfg(1'b1, {3'b010, 1'(b)}, 1'b1);
            check(b ? "R8 bit0=1 inverted init" : "R7 inverted init", 1'b1);
            in0 = 1'b1; tick(); tick();
            check(b ? "R8 bit0=1 inverted capture" : "R7 inverted capture", 1'b0);
        end

        // R9 stored bit held in table mode
        in0 = 1'b0; in1 = 1'b0;
        set_cfg(1'b1, 4'b0010, 1'b1);
        check("R9 setup init=1", 1'b1);
        set_cfg(1'b0, 4'b0000, 1'b0);
        tick();
        check("R9 table mode output", 1'b0);
        in0 = 1'b1; tick(); in0 = 1'b0; tick();
        in0 = 1'b1; tick(); in0 = 1'b0; tick();
        set_cfg(1'b1, 4'b0010, 1'b0);
        check("R9 stored bit retained", 1'b1);

        // R3 reset wins over a capture edge
        in0 = 1'b0; in1 = 1'b1; tick();
        in0 = 1'b1; cfg_field = 4'b0000; rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R3 reset over capture", 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule